// File: doc/BRIEF.md
# GPIO Port Register Block with Atomic Set and Clear

This block holds the output data register of one general-purpose I/O port and drives the port pins from it. Software reaches it over a small byte-wide register bus with an address, a write enable, write data and combinational read data. Besides a plain load of the output register, two side addresses let software change individual output bits in one write, with no read-modify-write.

A write to the clear address is active-low: each bit written as zero clears the matching output bit, and a one leaves it alone. A read of this address always returns zero. The set address serves two purposes. A write sets every output bit written as one. A read returns the pin levels after a two-flop synchroniser.

The port width and the mask of implemented bits are parameters. Reserved bits read as zero, never drive a pin, and ignore writes. The bus decoder turns each cycle into one operation: OP_IDLE, OP_LOAD, OP_CLEAR or OP_SET. A write enable at the load, clear or set address selects OP_LOAD, OP_CLEAR or OP_SET; any other cycle is OP_IDLE. The decoder also picks one read source: SEL_ODR, SEL_ZERO, SEL_PIN or SEL_NONE.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset the output register and `pin_out` are all zero, and the pin view reads zero until the synchroniser has refilled.
- R2: A write to address 0 loads `bus_wdata` masked by the implemented-bit mask (default 0x3E, bits 5..1) into the output register in the cycle after the write strobe.
- R3: A write to address 1 clears each implemented output bit whose write-data bit is 0, in the cycle after the strobe.
- R4: A write of 1 to a bit at address 1 leaves that output bit unchanged, and a read of address 1 always returns 0x00.
- R5: A write to address 2 sets each implemented output bit whose write-data bit is 1, and leaves the bits written 0 unchanged, in the cycle after the strobe.
- R6: A read of address 2 returns `pin_in` as it was two rising edges before, masked by the implemented-bit mask (1 = high, 0 = low), whatever write occurs in the same cycle.
- R7: Address 3 is unmapped: a read returns 0x00 and a write changes nothing.
- R8: `bus_rdata` follows `bus_addr` in the same cycle, and a read of address 0 returns the output register as it stood before any write in that cycle.
- R9: Reserved bit positions of `pin_out` and of every read are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address: 0 output data, 1 clear, 2 set/pin, 3 unmapped |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data for `bus_addr`, same cycle |
| pin_in | input | PORT_W | Asynchronous pin levels |
| pin_out | output | PORT_W | Output data register driving the pins |

## Verification
The set/pin address does two jobs in one cycle. A write there updates the output register, and the same address reads back the synchronised pin levels. The bench drives set writes at address 2 while `pin_in` changes on every cycle. It then checks that `bus_rdata` shows the pins from two edges earlier and never the write data, and that `pin_out` takes the set in the following cycle. It also loads or clears address 0 while reading it, and checks that the read shows the old value and the change appears one cycle later.

// File: rtl/gpio_atom_pkg.sv
package gpio_atom_pkg;

    // Register addresses; software depends on these positions.
    localparam int unsigned ADR_ODR    = 0;
    localparam int unsigned ADR_CLR    = 1;
    localparam int unsigned ADR_SETPIN = 2;

    // Operation applied to the output register in a cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_SET   = 2'd3
    } op_e;

    // Read-data source for a cycle.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ODR  = 2'd1,
        SEL_ZERO = 2'd2,
        SEL_PIN  = 2'd3
    } sel_e;

endpackage

// File: rtl/gpio_atom_decode.sv
module gpio_atom_decode
    import gpio_atom_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output op_e               op,
    output sel_e              rsel
);

    localparam logic [ADDR_W-1:0] A_ODR = ADDR_W'(ADR_ODR);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADR_CLR);
    localparam logic [ADDR_W-1:0] A_SP  = ADDR_W'(ADR_SETPIN);

    always_comb begin
        op   = OP_IDLE;
        rsel = SEL_NONE;
        if (addr == A_ODR) begin
            rsel = SEL_ODR;
            if (we) op = OP_LOAD;
        end else if (addr == A_CLR) begin
            rsel = SEL_ZERO;
            if (we) op = OP_CLEAR;
        end else if (addr == A_SP) begin
            rsel = SEL_PIN;
            if (we) op = OP_SET;
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int                PORT_W    = 8,
    parameter int                STAGES    = 2,
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_async,
    output logic [PORT_W-1:0] pin_sync
);

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin_async[b]};
            end
            assign pin_sync[b] = chain[STAGES-1];
        end else begin : g_rsvd
            assign pin_sync[b] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
    import gpio_atom_pkg::*;
#(
    parameter int                PORT_W    = 8,
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] odr
);

    logic [PORT_W-1:0] odr_q, odr_d;

    always_comb begin
        unique case (op)
            OP_IDLE:  odr_d = odr_q;
            OP_LOAD:  odr_d = wdata & IMPL_MASK;
            OP_CLEAR: odr_d = odr_q & (wdata | ~IMPL_MASK);
            OP_SET:   odr_d = odr_q | (wdata & IMPL_MASK);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) odr_q <= '0;
        else        odr_q <= odr_d;
    end

    assign odr = odr_q;

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_atom_pkg::*;
#(
    parameter int                PORT_W    = 8,
    parameter int                ADDR_W    = 2,
    parameter int                SYNC_LEN  = 2,
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out
);

    op_e               cur_op;
    sel_e              cur_sel;
    logic [PORT_W-1:0] odr;
    logic [PORT_W-1:0] pin_view;

    gpio_atom_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .op   (cur_op),
        .rsel (cur_sel)
    );

    gpio_out_reg #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_odr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (cur_op),
        .wdata (bus_wdata),
        .odr   (odr)
    );

    gpio_pin_sync #(.PORT_W(PORT_W), .STAGES(SYNC_LEN), .IMPL_MASK(IMPL_MASK)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_view)
    );

    always_comb begin
        unique case (cur_sel)
            SEL_NONE: bus_rdata = '0;
            SEL_ODR:  bus_rdata = odr;
            SEL_ZERO: bus_rdata = '0;
            SEL_PIN:  bus_rdata = pin_view & IMPL_MASK;
        endcase
    end

    assign pin_out = odr;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk #(
    parameter int                PORT_W    = 8,
    parameter int                ADDR_W    = 2,
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h3E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_in,
    input logic [PORT_W-1:0] pin_out
);

    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A3 = ADDR_W'(3);

    // Counts rising edges since reset release, saturating at 3.
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> pin_out == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A0) |=> pin_out == ($past(bus_wdata) & IMPL_MASK));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A1) |=>
        pin_out == ($past(pin_out) & ($past(bus_wdata) | ~IMPL_MASK)));

    assert_clr_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A1 |-> bus_rdata == '0);

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A2) |=>
        pin_out == ($past(pin_out) | ($past(bus_wdata) & IMPL_MASK)));

    assert_pin_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && bus_addr == A2) |-> bus_rdata == ($past(pin_in, 2) & IMPL_MASK));

    assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A3 |-> bus_rdata == '0);

    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || bus_addr == A3) |=> $stable(pin_out));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out | bus_rdata) & ~IMPL_MASK) == '0);

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(
    .PORT_W(PORT_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out)
);

// File: tb/tb_gpio_atomic_port.sv
`timescale 1ns/1ps
module tb_gpio_atomic_port;

    localparam int         W    = 8;
    localparam logic [7:0] MASK = 8'h3E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 1'b1;

    gpio_atomic_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Reference model: output value and a history of pin samples.
    logic [7:0] m_odr = '0;
    logic [7:0] m_pins[$] = '{8'h00, 8'h00};
    string      last_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_odr  = '0;
            m_pins = '{8'h00, 8'h00};
        end else begin
            if (bus_we) begin
                case (bus_addr)
                    2'd0: begin m_odr = bus_wdata & MASK;            last_tag = "R2"; end
                    2'd1: begin
                        for (int b = 0; b < W; b++)
                            if (MASK[b] && !bus_wdata[b]) m_odr[b] = 1'b0;
                        last_tag = "R3";
                    end
                    2'd2: begin
                        for (int b = 0; b < W; b++)
                            if (MASK[b] && bus_wdata[b]) m_odr[b] = 1'b1;
                        last_tag = "R5";
                    end
                    default: last_tag = "R7";
                endcase
            end
            m_pins.push_back(pin_in);
            void'(m_pins.pop_front());
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every clock, at the falling edge.
    always @(negedge clk) begin
        if (running && rst_n) begin
            logic [7:0] exp_rd;
            string      rtag;
            case (bus_addr)
                2'd0: begin exp_rd = m_odr;            rtag = "R8"; end
                2'd1: begin exp_rd = 8'h00;            rtag = "R4"; end
                2'd2: begin exp_rd = m_pins[0] & MASK; rtag = "R6"; end
                default: begin exp_rd = 8'h00;         rtag = "R7"; end
            endcase
            check(rtag, bus_rdata, exp_rd);
            check(last_tag, pin_out, m_odr);
            check("R9", (pin_out | bus_rdata) & ~MASK, 8'h00);
        end
    end

    task automatic drive(logic [1:0] a, logic we, logic [7:0] d, logic [7:0] p);
        @(posedge clk);
        #2;
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = d;
        pin_in    = p;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        pin_in = 8'hFF;
        repeat (3) @(posedge clk);
        // R1: reset state
        #2; check("R1", pin_out, 8'h00);
        rst_n = 1'b1;
        bus_addr = 2'd2;
        #1; check("R1", bus_rdata, 8'h00);
        // R2: load with reserved bits set
        drive(2'd0, 1'b1, 8'hFF, 8'hFF);
        drive(2'd0, 1'b0, 8'h00, 8'hFF);
        #4; check("R2", pin_out, 8'h3E);
        // R3 / R4: clear bits 1 and 3, ones untouched
        drive(2'd1, 1'b1, 8'hF5, 8'h00);
        drive(2'd1, 1'b0, 8'h00, 8'h00);
        #4; check("R3", pin_out, 8'h34);
        check("R4", bus_rdata, 8'h00);
        drive(2'd1, 1'b1, 8'hFF, 8'h00);
        drive(2'd0, 1'b0, 8'h00, 8'h00);
        #4; check("R4", pin_out, 8'h34);
        // R5: set bit 1, zeros no effect
        drive(2'd2, 1'b1, 8'h03, 8'hAA);
        drive(2'd0, 1'b0, 8'h00, 8'h55);
        #4; check("R5", pin_out, 8'h36);
        // R7: unmapped write
        drive(2'd3, 1'b1, 8'h00, 8'h55);
        drive(2'd3, 1'b0, 8'h00, 8'h55);
        #4; check("R7", pin_out, 8'h36);
        check("R7", bus_rdata, 8'h00);
        // R6: set writes while pins toggle every cycle
        for (int i = 0; i < 40; i++)
            drive(2'd2, 1'b1, (i % 3 == 0) ? 8'h00 : 8'(1 << (i % 8)), 8'(i * 37 + 5));
        for (int i = 0; i < 20; i++) drive(2'd1, 1'b1, 8'hFF, 8'(i * 53));
        // R8: load and clear while reading address 0
        drive(2'd0, 1'b1, 8'h2A, 8'h00);
        drive(2'd0, 1'b1, 8'h14, 8'h00);
        drive(2'd0, 1'b0, 8'h00, 8'h00);
        #4; check("R8", pin_out, 8'h14);
        // Mixed random traffic
        for (int i = 0; i < 3000; i++)
            drive(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  8'($urandom), 8'($urandom));
        // R1: reset in mid-run
        drive(2'd0, 1'b1, 8'hFF, 8'hFF);
        @(posedge clk); #2;
        rst_n = 1'b0;
        #1; check("R1", pin_out, 8'h00);
        repeat (2) @(posedge clk);
        #2; rst_n = 1'b1; bus_we = 1'b0; bus_addr = 2'd2;
        #1; check("R1", bus_rdata, 8'h00);
        repeat (4) drive(2'd2, 1'b0, 8'h00, 8'h22);
        drive(2'd3, 1'b0, 8'h00, 8'h00);
        @(posedge clk);
        running = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule